// File: doc/BRIEF.md
# Far-Return Stack Sequencer

This block is the control unit that carries out a far return, with an optional immediate byte count, for a simple 16-bit core. A one-cycle `start` pulse presents the immediate count `n`, the current code segment (its low two bits give the current privilege level) and the current stack segment and pointer. The block then reads the return offset and the return code segment from the stack and discards `n` bytes of parameters. If the returned code segment names a less privileged ring, it also reads a saved stack pointer and a saved stack segment. A return that stays in the same ring keeps the current stack segment and uses the adjusted pointer.

Memory is reached through one word-wide read port that follows valid/ready rules. The block raises `req_valid` with a segment and an offset. It then holds both steady, and keeps `req_valid` high, until it samples `req_ready` high on a clock edge. The word on `rd_data` is taken in that same edge. Memory applies back-pressure by holding `req_ready` low for as many cycles as it needs. Results are given as four registered outputs that change only together with a one-cycle `done` pulse. A request the block cannot honour ends in a one-cycle `fault` pulse and commits nothing.

Top module: `far_ret_seq`

## Requirements
- R1: After reset, `ret_cs`, `ret_ip`, `ret_ss` and `ret_sp` are 0, and `done`, `fault`, `busy` and `req_valid` are 0.
- R2: The first read is at offset SP and returns the new IP. The second read is at offset SP+2 and returns the new CS. Every read uses the stack segment latched at start.
- R3: A read completes only on an edge where `req_valid` and `req_ready` are both 1. While `req_ready` is 0, `req_valid` stays 1 and the segment and offset stay unchanged.
- R4: The privilege level is bits [1:0] of a code segment. When the returned CS has a level equal to the current one, `done` reports `ret_ss` = current SS and `ret_sp` = (SP + 4 + n) mod 65536, after exactly two reads.
- R5: When the returned CS has a level greater than the current one, the third read is at offset (SP + 4 + n) mod 65536 and gives `ret_sp`. The fourth read is at the next word and gives `ret_ss`. `done` follows after exactly four reads.
- R6: If bit 0 of `n` is 1, `fault` pulses on the cycle after the start edge, no read is issued and no output register changes.
- R7: When the returned CS has a level lower than the current one, `fault` pulses after two reads and no output register changes.
- R8: `done` and `fault` each last one cycle and are never high together. The four result outputs change only in the cycle in which `done` is high.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. The operation in progress completes with the inputs latched at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a far return (sampled while idle) |
| imm_bytes | input | 16 | Parameter bytes to discard (n) |
| cur_cs | input | 16 | Current code segment; bits [1:0] are the current level |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the read and drives rd_data this cycle |
| req_seg | output | 16 | Read segment |
| req_off | output | 16 | Read offset |
| rd_data | input | 16 | Read word, valid when req_valid and req_ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| ret_cs | output | 16 | Restored code segment |
| ret_ip | output | 16 | Restored instruction pointer |
| ret_ss | output | 16 | Restored stack segment |
| ret_sp | output | 16 | Restored stack pointer |

## Verification
The hardest case to reach is the fault on a return to a more privileged ring. It happens only after two reads have completed and the reads have advanced the working pointer, and it must still leave every result register exactly as it was. The bench's memory model returns words chosen by the request offset, so each run can set the level of the returned CS freely. The sweep covers every pair of current and returned levels under three `req_ready` stall patterns. Before each run, the bench records the results of the previous run, so it can check that a fault left them untouched.

// File: rtl/far_ret_pkg.sv
package far_ret_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_POP_IP = 3'd1,
    ST_POP_CS = 3'd2,
    ST_CHECK  = 3'd3,
    ST_POP_SP = 3'd4,
    ST_POP_SS = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_LOAD = 2'd1,
    SP_STEP = 2'd2,
    SP_SKIP = 2'd3
  } sp_op_e;
endpackage

// File: rtl/far_ret_ring_cmp.sv
module far_ret_ring_cmp #(
  parameter int PLW = 2
) (
  input  logic [PLW-1:0] cur_lvl,
  input  logic [PLW-1:0] new_lvl,
  output logic           to_outer,
  output logic           to_inner
);
  always_comb begin
    to_outer = new_lvl > cur_lvl;
    to_inner = new_lvl < cur_lvl;
  end
endmodule

// File: rtl/far_ret_sp_unit.sv
module far_ret_sp_unit
  import far_ret_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sp_op_e       op,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] skip_val,
  output logic [W-1:0] sp,
  output logic [W-1:0] sp_skipped
);
  localparam int STEP = W / 8;
  localparam logic [W-1:0] STEP_V = W'(STEP);

  assign sp_skipped = sp + skip_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
    end else begin
      unique case (op)
        SP_LOAD: sp <= load_val;
        SP_STEP: sp <= sp + STEP_V;
        SP_SKIP: sp <= sp_skipped;
        default: sp <= sp;
      endcase
    end
  end
endmodule

// File: rtl/far_ret_ctrl.sv
module far_ret_ctrl
  import far_ret_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       odd_count,
  input  logic       req_ready,
  input  logic       to_outer,
  input  logic       to_inner,
  output seq_state_e state,
  output logic       req_valid,
  output logic       fire,
  output sp_op_e     sp_op,
  output logic       latch_in,
  output logic       cap_ip,
  output logic       cap_cs,
  output logic       cap_sp,
  output logic       commit_same,
  output logic       commit_outer,
  output logic       fault_now
);
  seq_state_e nxt;

  always_comb begin
    nxt          = state;
    req_valid    = (state == ST_POP_IP) || (state == ST_POP_CS) ||
                   (state == ST_POP_SP) || (state == ST_POP_SS);
    fire         = req_valid && req_ready;
    sp_op        = SP_HOLD;
    latch_in     = 1'b0;
    cap_ip       = 1'b0;
    cap_cs       = 1'b0;
    cap_sp       = 1'b0;
    commit_same  = 1'b0;
    commit_outer = 1'b0;
    fault_now    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (odd_count) begin
            fault_now = 1'b1;
          end else begin
            latch_in = 1'b1;
            sp_op    = SP_LOAD;
            nxt      = ST_POP_IP;
          end
        end
      end
      ST_POP_IP: if (fire) begin
        cap_ip = 1'b1;
        sp_op  = SP_STEP;
        nxt    = ST_POP_CS;
      end
      ST_POP_CS: if (fire) begin
        cap_cs = 1'b1;
        sp_op  = SP_STEP;
        nxt    = ST_CHECK;
      end
      ST_CHECK: begin
        if (to_inner) begin
          fault_now = 1'b1;
          nxt       = ST_IDLE;
        end else if (to_outer) begin
          sp_op = SP_SKIP;
          nxt   = ST_POP_SP;
        end else begin
          commit_same = 1'b1;
          nxt         = ST_IDLE;
        end
      end
      ST_POP_SP: if (fire) begin
        cap_sp = 1'b1;
        sp_op  = SP_STEP;
        nxt    = ST_POP_SS;
      end
      ST_POP_SS: if (fire) begin
        commit_outer = 1'b1;
        nxt          = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_READ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !req_valid) else $error("idle read"); // R6
endmodule

// File: rtl/far_ret_seq.sv
module far_ret_seq
  import far_ret_pkg::*;
#(
  parameter int W   = 16,
  parameter int PLW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] imm_bytes,
  input  logic [W-1:0] cur_cs,
  input  logic [W-1:0] cur_ss,
  input  logic [W-1:0] cur_sp,
  output logic         req_valid,
  input  logic         req_ready,
  output logic [W-1:0] req_seg,
  output logic [W-1:0] req_off,
  input  logic [W-1:0] rd_data,
  output logic         busy,
  output logic         done,
  output logic         fault,
  output logic [W-1:0] ret_cs,
  output logic [W-1:0] ret_ip,
  output logic [W-1:0] ret_ss,
  output logic [W-1:0] ret_sp
);
  seq_state_e     state;
  sp_op_e         sp_op;
  logic           fire, latch_in, cap_ip, cap_cs, cap_sp;
  logic           commit_same, commit_outer, fault_now;
  logic           to_outer, to_inner;
  logic [W-1:0]   n_lat, ss_lat, ip_cap, cs_cap, sp_cap;
  logic [PLW-1:0] cpl_lat;
  logic [W-1:0]   sp_work, sp_skipped;

  far_ret_ctrl u_ctrl (
    .clk, .rst_n, .start,
    .odd_count(imm_bytes[0]), .req_ready,
    .to_outer, .to_inner, .state, .req_valid, .fire, .sp_op,
    .latch_in, .cap_ip, .cap_cs, .cap_sp,
    .commit_same, .commit_outer, .fault_now
  );

  far_ret_sp_unit #(.W(W)) u_sp (
    .clk, .rst_n, .op(sp_op),
    .load_val(cur_sp), .skip_val(n_lat),
    .sp(sp_work), .sp_skipped
  );

  far_ret_ring_cmp #(.PLW(PLW)) u_ring (
    .cur_lvl(cpl_lat), .new_lvl(cs_cap[PLW-1:0]),
    .to_outer, .to_inner
  );

  assign req_seg = ss_lat;
  assign req_off = sp_work;
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_lat   <= '0;
      ss_lat  <= '0;
      cpl_lat <= '0;
      ip_cap  <= '0;
      cs_cap  <= '0;
      sp_cap  <= '0;
    end else begin
      if (latch_in) begin
        n_lat   <= imm_bytes;
        ss_lat  <= cur_ss;
        cpl_lat <= cur_cs[PLW-1:0];
      end
      if (cap_ip) ip_cap <= rd_data;
      if (cap_cs) cs_cap <= rd_data;
      if (cap_sp) sp_cap <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      fault  <= 1'b0;
      ret_cs <= '0;
      ret_ip <= '0;
      ret_ss <= '0;
      ret_sp <= '0;
    end else begin
      done  <= commit_same || commit_outer;
      fault <= fault_now;
      if (commit_same) begin
        ret_cs <= cs_cap;
        ret_ip <= ip_cap;
        ret_ss <= ss_lat;
        ret_sp <= sp_skipped;
      end else if (commit_outer) begin
        ret_cs <= cs_cap;
        ret_ip <= ip_cap;
        ret_ss <= rd_data;
        ret_sp <= sp_cap;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_off) && $stable(req_seg)))
    else $error("request dropped"); // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)) else $error("done with fault"); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("long done"); // R8
  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ret_cs) && $stable(ret_ip) && $stable(ret_ss) && $stable(ret_sp)))
    else $error("result moved"); // R8
  AST_ODD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && imm_bytes[0]) |=> (fault && !busy)) else $error("odd n"); // R6
  AST_INNER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_CHECK) && (cs_cap[PLW-1:0] < cpl_lat)) |=> (fault && !busy))
    else $error("inner return"); // R7
endmodule

// File: tb/far_ret_seq_tb_top.sv
module far_ret_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] imm_bytes = '0, cur_cs = '0, cur_ss = '0, cur_sp = '0;
  logic        req_valid, req_ready;
  logic [15:0] req_seg, req_off, rd_data;
  logic        busy, done, fault;
  logic [15:0] ret_cs, ret_ip, ret_ss, ret_sp;

  int checks = 0, fails = 0;
  int reads = 0, cyc = 0, rdy_mode = 0;
  logic        seg_bad = 1'b0;
  logic [15:0] m_sp0, m_n, m_ip, m_cs, m_spw, m_ssw, m_ss;

  always #4 clk = ~clk;

  far_ret_seq dut_i (
    .clk, .rst_n, .start, .imm_bytes, .cur_cs, .cur_ss, .cur_sp,
    .req_valid, .req_ready, .req_seg, .req_off, .rd_data,
    .busy, .done, .fault, .ret_cs, .ret_ip, .ret_ss, .ret_sp
  );

  always_comb begin
    if (req_off == m_sp0)                     rd_data = m_ip;
    else if (req_off == 16'(m_sp0 + 16'd2))   rd_data = m_cs;
    else if (req_off == 16'(m_sp0 + 16'd4 + m_n)) rd_data = m_spw;
    else if (req_off == 16'(m_sp0 + 16'd6 + m_n)) rd_data = m_ssw;
    else                                      rd_data = 16'hDEAD;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (req_valid && req_ready) begin
      reads <= reads + 1;
      if (req_seg != m_ss) seg_bad <= 1'b1;
    end
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: req_ready <= 1'b1;
      1: req_ready <= cyc[0];
      default: req_ready <= (cyc % 3 == 2);
    endcase
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] cpl, input logic [1:0] rpl, input logic [15:0] n,
                     input logic [15:0] sp0, input bit disturb);
    logic [15:0] p_cs, p_ip, p_ss, p_sp;
    bit got_done, got_fault;
    int waited;
    p_cs = ret_cs; p_ip = ret_ip; p_ss = ret_ss; p_sp = ret_sp;
    m_sp0 = sp0; m_n = n; m_ss = 16'h3A00 ^ {14'd0, rpl};
    m_ip = 16'h1000 + 16'(sp0) ^ {n[7:0], 8'h11};
    m_cs = {14'h0C35, rpl};
    m_spw = 16'h7770 + n; m_ssw = 16'h5550 ^ sp0;
    reads = 0; seg_bad = 1'b0;
    @(negedge clk);
    cur_cs = {14'h0100, cpl}; cur_ss = m_ss; cur_sp = sp0; imm_bytes = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      cur_sp = 16'h4444; cur_ss = 16'h0; imm_bytes = 16'h0003; cur_cs = 16'h0003;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0; got_done = 0; got_fault = 0;
    while (!done && !fault && waited < 100) begin
      @(negedge clk); waited++;
    end
    got_done = done; got_fault = fault;
    if (waited >= 100) chk(0, "R8 timeout", 0, 1);
    if (n[0]) begin
      chk(got_fault && !got_done, "R6 fault", {got_done, got_fault}, 2'b01);
      chk(reads == 0, "R6 reads", reads, 0);
      chk({ret_cs, ret_ip, ret_ss, ret_sp} == {p_cs, p_ip, p_ss, p_sp}, "R6 no commit",
          {ret_cs, ret_ip, ret_ss, ret_sp}, {p_cs, p_ip, p_ss, p_sp});
    end else if (rpl < cpl) begin
      chk(got_fault && !got_done, "R7 fault", {got_done, got_fault}, 2'b01);
      chk(reads == 2, "R7 reads", reads, 2);
      chk({ret_cs, ret_ip, ret_ss, ret_sp} == {p_cs, p_ip, p_ss, p_sp}, "R7 no commit",
          {ret_cs, ret_ip, ret_ss, ret_sp}, {p_cs, p_ip, p_ss, p_sp});
    end else begin
      chk(got_done && !got_fault, "R8 done", {got_done, got_fault}, 2'b10);
      chk({ret_ip, ret_cs} == {m_ip, m_cs}, "R2 ip/cs", {ret_ip, ret_cs}, {m_ip, m_cs});
      chk(!seg_bad, "R2 segment", seg_bad, 0);
      if (rpl == cpl) begin
        chk(reads == 2, "R4 reads", reads, 2);
        chk({ret_ss, ret_sp} == {m_ss, 16'(sp0 + 16'd4 + n)}, "R4 stack",
            {ret_ss, ret_sp}, {m_ss, 16'(sp0 + 16'd4 + n)});
      end else begin
        chk(reads == 4, "R5 reads", reads, 4);
        chk({ret_ss, ret_sp} == {m_ssw, m_spw}, "R5 stack",
            {ret_ss, ret_sp}, {m_ssw, m_spw});
      end
      if (disturb) chk(ret_ip == m_ip, "R9 start ignored", ret_ip, m_ip);
    end
    @(negedge clk);
    chk(!done && !fault, "R8 pulse width", {done, fault}, 0);
  endtask

  initial begin
    req_ready = 1'b1;
    m_sp0 = 0; m_n = 0; m_ip = 0; m_cs = 0; m_spw = 0; m_ssw = 0; m_ss = 0;
    repeat (3) @(negedge clk);
    chk({ret_cs, ret_ip, ret_ss, ret_sp} == 64'd0, "R1 results", {ret_cs, ret_ip, ret_ss, ret_sp}, 0);
    chk({done, fault, busy, req_valid} == 4'd0, "R1 flags", {done, fault, busy, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      rdy_mode = m;
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          for (int k = 0; k < 5; k++) begin
            logic [15:0] nv;
            case (k)
              0: nv = 16'd0;
              1: nv = 16'd2;
              2: nv = 16'd6;
              3: nv = 16'd1;
              default: nv = 16'h7FFE;
            endcase
            run(c[1:0], r[1:0], nv, 16'h0100, 1'b0);
            run(c[1:0], r[1:0], nv, 16'hFFFA, 1'b0);
          end
    end
    rdy_mode = 1;
    run(2'd1, 2'd3, 16'd4, 16'h0200, 1'b1);
    run(2'd2, 2'd2, 16'd2, 16'h0300, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule